// File: doc/BRIEF.md
# NCO With Complex Mixer

This block shifts a complex baseband stream up in frequency. A 32-bit phase accumulator adds a programmable frequency word on every clock. Each wrap of the accumulator is exported as a one-cycle carry pulse, so the carry rate runs from the full clock rate down to one pulse every 2^32 clocks. A 16-bit phase offset can be loaded into the accumulator's upper half, and a clear input returns the accumulator to zero, for example to re-align the carry on a slow periodic event.

The top ten accumulator bits address a sine/cosine generator. It stores one quarter of a sine period in 256 entries and builds the other three quarters by mirroring the address and negating the result. Each accepted 21-bit I/Q sample is rotated by the 19-bit cosine and sine of the phase that the accumulator held when the sample arrived. The results are rounded and saturated back to 21 bits, and the valid flag is delayed through the same pipeline.

Top module: `nco_mixer`

## Requirements
- R1: While rst_ni is low, phase_o, carry_o, valid_o, re_o and im_o are all zero.
- R2: With clear_i and load_i low, phase_o advances by freq_i modulo 2^32 on every clock edge.
- R3: carry_o is high for exactly the cycle after an advance whose unsigned sum reached 2^32. It is low after a clear or a load.
- R4: With load_i high and clear_i low, the next phase_o is {offset_i, 16'h0000}, whatever freq_i is.
- R5: clear_i high sets the next phase_o to zero and takes priority over load_i.
- R6: For the phase index p = phase_o[31:22], the sine is round(262143*sin(2*pi*(p+0.5)/1024)) and the cosine is the sine of index (p+256) mod 1024. Both are signed 19-bit values with rounding away from zero, and -262144 never appears.
- R7: For a sample accepted at a clock edge, with p taken from phase_o just before that edge, the outputs are re = I*cos - Q*sin and im = Q*cos + I*sin.
- R8: Each 41-bit sum is scaled as (sum + 2^17) >>> 18, an arithmetic shift.
- R9: Scaled results above 1048575 become 1048575, and results below -1048576 become -1048576.
- R10: valid_o rises exactly three clock edges after a sample is accepted on valid_i. re_o and im_o hold their values while no result is delivered, and each sample produces exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freq_i | input | 32 | Phase increment added per clock |
| clear_i | input | 1 | Zero the accumulator |
| load_i | input | 1 | Load the offset into the accumulator's upper half |
| offset_i | input | 16 | Carrier phase offset |
| valid_i | input | 1 | I/Q sample valid |
| i_i | input | 21 | In-phase sample, two's complement |
| q_i | input | 21 | Quadrature sample, two's complement |
| phase_o | output | 32 | Accumulator state |
| carry_o | output | 1 | Accumulator wrap pulse |
| valid_o | output | 1 | Rotated sample valid |
| re_o | output | 21 | Real output |
| im_o | output | 21 | Imaginary output |

## Verification
The assertions watch four things on every cycle: clear and load priority, the match between a carry pulse and a phase that went backwards, the generator never producing the most negative code, and the held outputs plus the saturation threshold in the mixer. Only the bench scenarios can show the numerical behaviour. These scenarios check the table contents over all 1024 phase indices, the sign convention of the rotation, the rounding of scaled products, the exact three-edge latency under gapped valid patterns, and the carry after a wrap.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  localparam int NCO_PHASE_W = 32;
  localparam int NCO_OFF_W   = 16;
  localparam int NCO_IDX_W   = 10;
  localparam int NCO_TRIG_W  = 19;
  localparam int NCO_DATA_W  = 21;

  typedef enum logic [1:0] {QD_0, QD_1, QD_2, QD_3} quad_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = nco_mix_pkg::NCO_PHASE_W,
  parameter int OFF_W   = nco_mix_pkg::NCO_OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic               clear_i,
  input  logic               load_i,
  input  logic [OFF_W-1:0]   offset_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               carry_o
);
  localparam int LOW_W = PHASE_W - OFF_W;

  logic [PHASE_W-1:0] acc_q;
  logic               carry_q;
  logic [PHASE_W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (clear_i) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (load_i) begin
      acc_q   <= {offset_i, {LOW_W{1'b0}}};
      carry_q <= 1'b0;
    end else begin
      acc_q   <= sum[PHASE_W-1:0];
      carry_q <= sum[PHASE_W];
    end
  end

  assign phase_o = acc_q;
  assign carry_o = carry_q;

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0 && !carry_q));
  p_load_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (acc_q[PHASE_W-1 -: OFF_W] == $past(offset_i) && acc_q[LOW_W-1:0] == '0));
  // a wrap is the only way an advance can move the phase backwards
  p_carry_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !load_i) |=> (carry_q == ($past(acc_q) > acc_q)));
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int IDX_W  = nco_mix_pkg::NCO_IDX_W,
  parameter int TRIG_W = nco_mix_pkg::NCO_TRIG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W-1:0]         idx_i,
  output logic signed [TRIG_W-1:0] sin_o,
  output logic signed [TRIG_W-1:0] cos_o
);
  import nco_mix_pkg::*;

  localparam int  FINE_W = IDX_W - 2;
  localparam int  QN     = 1 << FINE_W;
  localparam int  AMP    = (1 << (TRIG_W - 1)) - 1;
  localparam real PI     = 3.14159265358979323846;

  logic [TRIG_W-1:0] rom [QN];

  for (genvar k = 0; k < QN; k++) begin : g_rom
    localparam real ANG = (real'(k) + 0.5) * 2.0 * PI / real'(4 * QN);
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
    assign rom[k] = TRIG_W'(VAL);
  end

  quad_e             quad;
  logic [FINE_W-1:0] fine, s_addr, c_addr;
  logic              s_neg, c_neg;
  logic signed [TRIG_W-1:0] s_mag, c_mag, s_d, c_d;

  always_comb begin
    quad = quad_e'(idx_i[IDX_W-1 -: 2]);
    fine = idx_i[FINE_W-1:0];
    unique case (quad)
      QD_0: begin s_addr = fine;  s_neg = 1'b0; c_addr = ~fine; c_neg = 1'b0; end
      QD_1: begin s_addr = ~fine; s_neg = 1'b0; c_addr = fine;  c_neg = 1'b1; end
      QD_2: begin s_addr = fine;  s_neg = 1'b1; c_addr = ~fine; c_neg = 1'b1; end
      default: begin s_addr = ~fine; s_neg = 1'b1; c_addr = fine; c_neg = 1'b0; end
    endcase
    s_mag = $signed(rom[s_addr]);
    c_mag = $signed(rom[c_addr]);
    s_d   = s_neg ? -s_mag : s_mag;
    c_d   = c_neg ? -c_mag : c_mag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= s_d;
      cos_o <= c_d;
    end
  end

  p_sin_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sin_o != {1'b1, {(TRIG_W-1){1'b0}}});
  p_cos_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cos_o != {1'b1, {(TRIG_W-1){1'b0}}});
endmodule

// File: rtl/nco_cmix.sv
module nco_cmix #(
  parameter int DATA_W = nco_mix_pkg::NCO_DATA_W,
  parameter int TRIG_W = nco_mix_pkg::NCO_TRIG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  input  logic signed [TRIG_W-1:0] sin_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] re_o,
  output logic signed [DATA_W-1:0] im_o
);
  localparam int PW = DATA_W + TRIG_W;
  localparam int SW = PW + 1;
  localparam int SH = TRIG_W - 1;
  localparam logic signed [SW-1:0] HALF   = SW'(1) <<< (SH - 1);
  localparam logic signed [SW-1:0] MAXV   = (SW'(1) <<< (DATA_W - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV   = -(SW'(1) <<< (DATA_W - 1));
  localparam logic signed [SW-1:0] HI_LIM = (SW'(1) <<< (DATA_W - 1 + SH)) - HALF;

  logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [SW-1:0] re_sum_q, im_sum_q;
  logic                 sum_vld_q;

  always_comb begin
    p_ic = PW'(i_i) * PW'(cos_i);
    p_qs = PW'(q_i) * PW'(sin_i);
    p_qc = PW'(q_i) * PW'(cos_i);
    p_is = PW'(i_i) * PW'(sin_i);
  end

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] y;
    y = (x + HALF) >>> SH;
    if (y > MAXV)      return MAXV[DATA_W-1:0];
    else if (y < MINV) return MINV[DATA_W-1:0];
    else               return y[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_vld_q <= 1'b0;
      re_sum_q  <= '0;
      im_sum_q  <= '0;
      valid_o   <= 1'b0;
      re_o      <= '0;
      im_o      <= '0;
    end else begin
      sum_vld_q <= valid_i;
      if (valid_i) begin
        re_sum_q <= SW'(p_ic) - SW'(p_qs);
        im_sum_q <= SW'(p_qc) + SW'(p_is);
      end
      valid_o <= sum_vld_q;
      if (sum_vld_q) begin
        re_o <= rnd_sat(re_sum_q);
        im_o <= rnd_sat(im_sum_q);
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum_vld_q |=> ($stable(re_o) && $stable(im_o)));
  p_sat_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_q && re_sum_q >= HI_LIM) |=> (re_o == MAXV[DATA_W-1:0]));
  p_sat_hi_im_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_q && im_sum_q >= HI_LIM) |=> (im_o == MAXV[DATA_W-1:0]));
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
  parameter int PHASE_W = nco_mix_pkg::NCO_PHASE_W,
  parameter int OFF_W   = nco_mix_pkg::NCO_OFF_W,
  parameter int IDX_W   = nco_mix_pkg::NCO_IDX_W,
  parameter int TRIG_W  = nco_mix_pkg::NCO_TRIG_W,
  parameter int DATA_W  = nco_mix_pkg::NCO_DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PHASE_W-1:0]       freq_i,
  input  logic                     clear_i,
  input  logic                     load_i,
  input  logic [OFF_W-1:0]         offset_i,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] i_i,
  input  logic signed [DATA_W-1:0] q_i,
  output logic [PHASE_W-1:0]       phase_o,
  output logic                     carry_o,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] re_o,
  output logic signed [DATA_W-1:0] im_o
);
  logic [PHASE_W-1:0]       phase;
  logic signed [TRIG_W-1:0] sin_q, cos_q;
  logic signed [DATA_W-1:0] i_q, q_q;
  logic                     vld_q;

  nco_phase_acc #(.PHASE_W(PHASE_W), .OFF_W(OFF_W)) u_acc (
    .clk_i, .rst_ni, .freq_i, .clear_i, .load_i, .offset_i,
    .phase_o(phase), .carry_o
  );

  nco_sincos #(.IDX_W(IDX_W), .TRIG_W(TRIG_W)) u_lut (
    .clk_i, .rst_ni, .idx_i(phase[PHASE_W-1 -: IDX_W]),
    .sin_o(sin_q), .cos_o(cos_q)
  );

  // sample aligned with the table output of the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      i_q   <= '0;
      q_q   <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        i_q <= i_i;
        q_q <= q_i;
      end
    end
  end

  nco_cmix #(.DATA_W(DATA_W), .TRIG_W(TRIG_W)) u_mix (
    .clk_i, .rst_ni, .valid_i(vld_q), .i_i(i_q), .q_i(q_q),
    .sin_i(sin_q), .cos_i(cos_q), .valid_o, .re_o, .im_o
  );

  assign phase_o = phase;
endmodule

// File: tb/nco_mixer_test.sv
module nco_mixer_test;
  localparam int  CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979323846;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [31:0]        freq_i = '0;
  logic               clear_i = 1'b0;
  logic               load_i = 1'b0;
  logic [15:0]        offset_i = '0;
  logic               valid_i = 1'b0;
  logic signed [20:0] i_i = '0;
  logic signed [20:0] q_i = '0;
  logic [31:0]        phase_o;
  logic               carry_o;
  logic               valid_o;
  logic signed [20:0] re_o;
  logic signed [20:0] im_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_acc = '0;
  int    q_re[$], q_im[$], q_at[$];
  string q_tag[$];
  int    last_re = 0, last_im = 0, n_push = 0, n_pop = 0;

  nco_mixer uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int trig_ref(input int p);
    real v;
    v = 262143.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int rnd_sat_ref(input longint x);
    longint y;
    y = (x + 64'sd131072) >>> 18;
    if (y > 1048575) y = 1048575;
    if (y < -1048576) y = -1048576;
    return int'(y);
  endfunction

  // drive one cycle; push expected result; check phase and carry after the edge
  task automatic step(input logic [31:0] f, input bit clr, input bit ld, input logic [15:0] off,
                      input bit v, input int iv, input int qv, input string tag);
    logic [32:0] s;
    bit exp_c;
    int p, c, sn;
    @(negedge clk_i);
    freq_i = f; clear_i = clr; load_i = ld; offset_i = off;
    valid_i = v; i_i = 21'(iv); q_i = 21'(qv);
    if (v) begin
      p  = int'(m_acc[31:22]);
      c  = trig_ref((p + 256) % 1024);
      sn = trig_ref(p);
      q_re.push_back(rnd_sat_ref(longint'(iv) * c - longint'(qv) * sn));
      q_im.push_back(rnd_sat_ref(longint'(qv) * c + longint'(iv) * sn));
      q_at.push_back(cyc + 3);
      q_tag.push_back(tag);
      n_push++;
    end
    if (clr) begin m_acc = '0; exp_c = 1'b0; end
    else if (ld) begin m_acc = {off, 16'h0}; exp_c = 1'b0; end
    else begin s = {1'b0, m_acc} + {1'b0, f}; m_acc = s[31:0]; exp_c = s[32]; end
    @(posedge clk_i); #1;
    check({tag, " phase"}, phase_o, m_acc);
    check({tag, " carry R3"}, carry_o, exp_c);
  endtask

  // monitor: pop and compare on every delivered result
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (q_re.size() == 0) begin
        check("R10 unexpected valid_o", 1, 0);
      end else begin
        string t;
        int er, ei, at;
        er = q_re.pop_front(); ei = q_im.pop_front(); at = q_at.pop_front(); t = q_tag.pop_front();
        n_pop++;
        check({t, " re"}, int'(re_o), er);
        check({t, " im"}, int'(im_o), ei);
        check({t, " latency R10"}, cyc, at);
        last_re = er; last_im = ei;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 phase", phase_o, 0);
    check("R1 carry", carry_o, 0);
    check("R1 valid", valid_o, 0);
    check("R1 re", re_o, 0);
    check("R1 im", im_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 advance
    for (int k = 0; k < 6; k++) step(32'h0123_4567, 0, 0, 0, 0, 0, 0, "R2 advance");
    // R4 load ignores freq, R3 wrap after load near top
    step(32'h7777_7777, 0, 1, 16'hFFFF, 0, 0, 0, "R4 load");
    step(32'h0001_0000, 0, 0, 0, 0, 0, 0, "R3 wrap");
    step(32'h0000_0001, 0, 0, 0, 0, 0, 0, "R3 after wrap");
    step(32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R3 large step");
    step(32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R3 large step");
    // R5 clear beats load
    step(32'h1111_1111, 1, 1, 16'hABCD, 0, 0, 0, "R5 clear over load");
    step(32'h0000_0000, 0, 0, 0, 0, 0, 0, "R5 hold zero");

    // R6 table sweep over all 1024 indices with pure I input
    step(32'h0040_0000, 1, 0, 0, 0, 0, 0, "R6 start");
    for (int k = 0; k < 1024; k++) step(32'h0040_0000, 0, 0, 0, 1, 1048575, 0, "R6 table");
    // R7/R8 mixed signs, non-integer step
    for (int k = 0; k < 40; k++)
      step(32'h0137_0000, 0, 0, 0, 1, 300000 - k * 13000, -150000 + k * 7001, "R7 R8 rotate");
    // R9 saturation near 45 degrees
    step(32'h0, 0, 1, 16'h2000, 0, 0, 0, "R9 set phase");
    step(32'h0, 0, 0, 0, 1, -1048576, -1048576, "R9 sat low");
    step(32'h0, 0, 0, 0, 1, 1048575, 1048575, "R9 sat high");
    step(32'h0, 0, 1, 16'hA000, 0, 0, 0, "R9 set phase");
    step(32'h0, 0, 0, 0, 1, 1048575, -1048576, "R9 sat mixed");
    // R10 gapped valid pattern, then hold check
    for (int k = 0; k < 12; k++)
      step(32'h0523_0000, 0, 0, 0, (k % 3) != 1, 5000 * k - 30000, 70000 - 9000 * k, "R10 gapped");
    for (int k = 0; k < 6; k++) step(32'h0, 0, 0, 0, 0, 0, 0, "R10 idle");
    check("R10 re held", int'(re_o), last_re);
    check("R10 im held", int'(im_o), last_im);
    check("R10 all delivered", n_pop, n_push);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule